// File: doc/BRIEF.md
# Inter-Core Mailbox Register Bank

This block keeps sixteen 32-bit doorbell words that processor cores use to signal one another. There are four cores, and each owns four words. A sender raises bits in a word by writing through the set window. The receiver reads the word through the clear window, then writes back the bits it has handled, which clears them. A 16-bit pending vector marks every word that holds a nonzero value, and a separate interrupt router consumes it.

The bus side is a plain single-cycle port. A strobe, a write flag, a byte address, write data and registered read data are all it has. Read data appears in the cycle after the request. A small response machine has two states. `RSP_IDLE` drives zero on the read-data output. `RSP_DATA` presents the captured word for exactly one cycle. The machine goes from `RSP_IDLE` to `RSP_DATA` on a read hit in the clear window. It goes from `RSP_DATA` back to `RSP_IDLE` when no hit follows, and it stays in `RSP_DATA` while reads arrive back to back. Every address outside the two windows is left alone, so the bank can share a bus decode with the router's own registers.

Top module: `mbx_bank`

## Requirements
- R1: After reset every word is zero, `box_pending` is all zeros and `acc_rdata` is zero.
- R2: A write with `acc_addr` = 0x80 + 4·n (n in 0..15) ORs `acc_wdata` into word n.
- R3: A write with `acc_addr` = 0xC0 + 4·n clears each bit of word n whose `acc_wdata` bit is one, and leaves every other bit unchanged.
- R4: A read with `acc_addr` = 0xC0 + 4·n returns the content of word n on `acc_rdata` in the cycle after the request. The output is zero again in the next cycle unless another read hit follows. A read does not change the word.
- R5: A read in the set window (0x80 to 0xBF) returns zero.
- R6: Bit n of `box_pending` is one exactly when word n is nonzero. It changes on the clock edge that applies a write, and it holds while no write is applied.
- R7: An access whose address lies below 0x80, or whose two low address bits are not zero, changes no word and leaves `acc_rdata` at zero.
- R8: Word index n equals core·4 + box. Bit n of `box_pending` therefore carries the pending flag for box `box` of core `core`.
- R9: A write changes only the one word it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address of a 32-bit word |
| acc_wdata | input | 32 | Write data (set mask or clear mask) |
| acc_rdata | output | 32 | Read data, valid the cycle after a read hit, zero otherwise |
| box_pending | output | 16 | One bit per word, high when that word is nonzero |

## Verification
The properties assume that each access on the port is a single-cycle strobe with a stable address and stable data. They also assume that `acc_write` and `acc_wdata` are known whenever `acc_valid` is high. The bench drives all inputs on the falling edge and lowers `acc_valid` after every access. The vectors deliberately cover unaligned addresses, addresses below the windows, and full-ones masks at the top word. This exercises the decode edges at 0x80, 0xBC, 0xC0 and 0xFC without ever presenting an undefined value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Which alias window an access falls into
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } win_e;

    // Read response machine states
    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_DATA = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_BOX  = 16,
    parameter int unsigned IDX_W    = 4,
    parameter int unsigned SET_BASE = 'h80,
    parameter int unsigned CLR_BASE = 'hC0
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned SPAN    = NUM_BOX * 4;
    localparam int unsigned SET_END = SET_BASE + SPAN;
    localparam int unsigned CLR_END = CLR_BASE + SPAN;

    logic [ADDR_W:0]   a_ext;
    logic [ADDR_W-1:0] set_off;
    logic [ADDR_W-1:0] clr_off;
    logic              aligned;
    logic              in_set;
    logic              in_clr;

    assign a_ext   = {1'b0, addr};
    assign aligned = (addr[1:0] == 2'b00);
    assign set_off = addr - ADDR_W'(SET_BASE);
    assign clr_off = addr - ADDR_W'(CLR_BASE);
    assign in_set  = aligned && (a_ext >= (ADDR_W+1)'(SET_BASE)) && (a_ext < (ADDR_W+1)'(SET_END));
    assign in_clr  = aligned && (a_ext >= (ADDR_W+1)'(CLR_BASE)) && (a_ext < (ADDR_W+1)'(CLR_END));

    always_comb begin
        win = WIN_NONE;
        idx = '0;
        if (in_set) begin
            win = WIN_SET;
            idx = set_off[IDX_W+1:2];
        end else if (in_clr) begin
            win = WIN_CLR;
            idx = clr_off[IDX_W+1:2];
        end
    end
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] word,
    output logic              busy
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (set_en) begin
            word <= word | mask;
        end else if (clr_en) begin
            word <= word & ~mask;
        end
    end

    assign busy = |word;
endmodule

// File: rtl/mbx_rsp_fsm.sv
module mbx_rsp_fsm
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rdata
);
    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [DATA_W-1:0] hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = rd_hit ? RSP_DATA : RSP_IDLE;
            RSP_DATA: state_d = rd_hit ? RSP_DATA : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_hit) begin
                hold_q <= rd_word;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            RSP_DATA: rdata = hold_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CORES    = 4,
    parameter int unsigned BOX_PER_CORE = 4,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned SET_BASE     = 'h80,
    parameter int unsigned CLR_BASE     = 'hC0,
    localparam int unsigned NUM_BOX     = NUM_CORES * BOX_PER_CORE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic [NUM_BOX-1:0] box_pending
);
    localparam int unsigned IDX_W = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1;

    win_e              win;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] words [NUM_BOX];
    logic              rd_hit;
    logic [DATA_W-1:0] rd_word;

    mbx_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_BOX (NUM_BOX),
        .IDX_W   (IDX_W),
        .SET_BASE(SET_BASE),
        .CLR_BASE(CLR_BASE)
    ) u_decode (
        .addr(acc_addr),
        .win (win),
        .idx (idx)
    );

    // Word n = core*BOX_PER_CORE + box
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar b = 0; b < BOX_PER_CORE; b++) begin : g_box
            localparam int unsigned N = c * BOX_PER_CORE + b;
            logic sel;
            assign sel = acc_valid && acc_write && (idx == IDX_W'(N));
            mbx_cell #(.DATA_W(DATA_W)) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_en(sel && (win == WIN_SET)),
                .clr_en(sel && (win == WIN_CLR)),
                .mask  (acc_wdata),
                .word  (words[N]),
                .busy  (box_pending[N])
            );
        end
    end

    assign rd_hit  = acc_valid && !acc_write && (win == WIN_CLR);
    assign rd_word = words[idx];

    mbx_rsp_fsm #(.DATA_W(DATA_W)) u_rsp (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (rd_hit),
        .rd_word(rd_word),
        .rdata  (acc_rdata)
    );
endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
    parameter int unsigned NUM_BOX  = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned SET_BASE = 'h80,
    parameter int unsigned CLR_BASE = 'hC0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] acc_rdata,
    input logic [NUM_BOX-1:0] box_pending
);
    localparam int unsigned IDX_W = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1;
    localparam int unsigned SPAN  = NUM_BOX * 4;

    logic              ok_align;
    logic              hit_set;
    logic              hit_clr;
    logic [ADDR_W-1:0] off_set;
    logic [ADDR_W-1:0] off_clr;
    logic [IDX_W-1:0]  n_set;
    logic [IDX_W-1:0]  n_clr;
    logic              rd_q;
    logic              pend_at_req;

    assign ok_align = (acc_addr[1:0] == 2'b00);
    assign hit_set  = ok_align && (int'(acc_addr) >= int'(SET_BASE)) && (int'(acc_addr) < int'(SET_BASE + SPAN));
    assign hit_clr  = ok_align && (int'(acc_addr) >= int'(CLR_BASE)) && (int'(acc_addr) < int'(CLR_BASE + SPAN));
    assign off_set  = acc_addr - ADDR_W'(SET_BASE);
    assign off_clr  = acc_addr - ADDR_W'(CLR_BASE);
    assign n_set    = off_set[IDX_W+1:2];
    assign n_clr    = off_clr[IDX_W+1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q        <= 1'b0;
            pend_at_req <= 1'b0;
        end else begin
            rd_q        <= acc_valid && !acc_write && hit_clr;
            pend_at_req <= box_pending[n_clr];
        end
    end

    // R2, R6: a nonzero set mask makes the addressed word pending
    p_set_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && hit_set && (acc_wdata != '0)) |=> box_pending[$past(n_set)]);

    // R3: an all-ones clear mask empties the addressed word
    p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && hit_clr && (&acc_wdata)) |=> !box_pending[$past(n_clr)]);

    // R4: read data is nonzero exactly when the word was pending at the request
    p_read_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> ((acc_rdata != '0) == pend_at_req));

    // R5, R7: no clear-window read in the previous cycle means zero read data
    p_rdata_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_q |-> (acc_rdata == '0));

    // R6: without a write the pending vector holds
    p_pending_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write) |=> $stable(box_pending));

    // R7: a write outside both windows leaves the pending vector alone
    p_outside_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !hit_set && !hit_clr) |=> $stable(box_pending));
endmodule

bind mbx_bank mbx_bank_chk #(
    .NUM_BOX (NUM_BOX),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE)
) u_chk (.*);

// File: tb/test_mbx_bank.sv
module test_mbx_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [15:0] box_pending;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mbx_bank i_mbx_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .acc_rdata  (acc_rdata),
        .box_pending(box_pending)
    );

    // wr=1: exp is the pending vector after the write; wr=0: exp is read data
    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h80, 32'h0000_0005, 32'h0000_0001},  // R2 set word 0
        '{1'b1, 8'h80, 32'h0000_0100, 32'h0000_0001},  // R2 OR more bits
        '{1'b0, 8'hC0, 32'h0,         32'h0000_0105},  // R4 read word 0
        '{1'b1, 8'hBC, 32'h8000_0000, 32'h0000_8001},  // R9 word 15 only
        '{1'b1, 8'hC0, 32'h0000_0004, 32'h0000_8001},  // R3 partial clear
        '{1'b0, 8'hC0, 32'h0,         32'h0000_0101},  // R3 remaining bits
        '{1'b0, 8'h80, 32'h0,         32'h0000_0000},  // R5 set window read
        '{1'b1, 8'hC0, 32'h0000_0101, 32'h0000_8000},  // R6 flag drops
        '{1'b1, 8'h94, 32'hA5A5_0000, 32'h0000_8020},  // R8 core 1 box 1
        '{1'b0, 8'hD4, 32'h0,         32'hA5A5_0000},  // R8 read back
        '{1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0000_8020},  // R7 outside window
        '{1'b0, 8'h40, 32'h0,         32'h0000_0000},  // R7 outside read
        '{1'b1, 8'hFC, 32'hFFFF_FFFF, 32'h0000_0020},  // R3 top word cleared
        '{1'b1, 8'h95, 32'h0000_0001, 32'h0000_0020},  // R7 unaligned write
        '{1'b0, 8'hD4, 32'h0,         32'hA5A5_0000}   // R7 word 5 intact
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_access(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = a;
        acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
        acc_wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pending at reset", {16'h0, box_pending}, 32'h0);
        check("R1 rdata at reset", acc_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            do_access(VECS[v].wr, VECS[v].addr, VECS[v].data);
            if (VECS[v].wr)
                check($sformatf("R2/R3/R6 vector %0d pending", v), {16'h0, box_pending}, VECS[v].exp);
            else
                check($sformatf("R4/R5 vector %0d rdata", v), acc_rdata, VECS[v].exp);
        end

        // R4: read data lasts one cycle only
        do_access(1'b0, 8'hD4, 32'h0);
        check("R4 rdata presented", acc_rdata, 32'hA5A5_0000);
        @(negedge clk);
        check("R4 rdata back to zero", acc_rdata, 32'h0);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pending after mid reset", {16'h0, box_pending}, 32'h0);
        rst_n = 1'b1;
        do_access(1'b0, 8'hD4, 32'h0);
        check("R1 word 5 cleared by reset", acc_rdata, 32'h0);

        // R8, R9: fill every word in index order and read each back
        for (int n = 0; n < 16; n++) begin
            do_access(1'b1, 8'(8'h80 + 4 * n), 32'h1 << n);
            check($sformatf("R8 pending after word %0d set", n), {16'h0, box_pending},
                  32'((17'h1 << (n + 1)) - 17'h1));
        end
        for (int n = 0; n < 16; n++) begin
            do_access(1'b0, 8'(8'hC0 + 4 * n), 32'h0);
            check($sformatf("R9 word %0d content", n), acc_rdata, 32'h1 << n);
        end

        // R3: clear of unset bits keeps the word
        do_access(1'b1, 8'hC8, 32'hFFFF_FFFB);
        check("R3 clear other bits keeps word 2", {16'h0, box_pending}, 32'h0000_FFFF);
        do_access(1'b1, 8'hC8, 32'h0000_0004);
        check("R3 clear last bit of word 2", {16'h0, box_pending}, 32'h0000_FFFB);

        finish_run();
    end
endmodule